// File: doc/BRIEF.md
# DMA Controller Command, Mask and Status Port

This block is the control-register file of a four-channel DMA controller. A host bus reaches it through eight control offsets. Each offset has one meaning on a write and another on a read. Through them the host sets the controller-wide command, turns individual channel requests on and off, masks channels, and programs each channel's 8-bit mode. It also reads back status, the pending requests and the mask, and walks through the channel modes with a small readback counter. Some reads and writes have side effects: reading status clears the terminal-count flags, and reading a mode advances the counter. A master-clear write returns the controller to its idle state.

Toward the data mover, the block takes a per-channel request level and a per-channel terminal-count pulse. It returns one service-request line per channel. Address and count registers are outside this block, but they share a byte-pointer flip-flop. For that flip-flop the block drives a clear strobe and a set strobe during the access that calls for them. A parameter selects the word-spaced variant of the decoder. In that variant every offset is spread over two bus addresses, and the low address bit is ignored.

Top module: `dma_ctl_port`

## Requirements
- R1: After synchronous active-low reset, the block is in this state. The command is 0x00. Status reads 0x00. The request read gives 0xF0. The mask read gives 0x0F, so all channels are masked. Every channel mode is 0x00, so the first mode read returns 0x03. All service requests are low.
- R2: A write to offset 0 loads the command byte only when bits 0, 1, 3, 5, 6 and 7 are all zero. Any other value leaves the command unchanged. A read of offset 2 returns the command byte.
- R3: A write to offset 1 selects a channel with data bits [1:0] and sets that channel's software request flag to data bit 2. The same write clears that channel's terminal-count flag.
- R4: Three writes change the mask. A write to offset 2 sets the mask bit of the channel named by bits [1:0] to data bit 2. A write to offset 6 unmasks all channels. A write to offset 7 loads all four mask bits from data bits [3:0]. A read of offset 7 returns {4'b0000, mask}.
- R5: A write to offset 3 stores the whole byte as the mode of the channel named by bits [1:0]. A read of offset 3 returns the mode of the channel selected by a 2-bit counter, with bits [1:0] forced to 1. The same read then advances the counter modulo 4. A read of offset 6 resets the counter to 0.
- R6: A read of offset 0 returns {request[3:0], terminal_count[3:0]} and then clears the terminal-count bits. A read of offset 1 returns {4'b1111, request[3:0]}. A channel's request bit is the OR of its software flag and its hardware request input.
- R7: A terminal-count pulse on a channel sets its status bit, except when the mode bits [7:6] of that channel equal 2'b11 (cascade). If a pulse arrives in the same cycle as a status read, the set wins.
- R8: The service request for channel i is high exactly when command bit 2 is 0, mask bit i is 0, and request bit i is 1.
- R9: The byte-pointer clear strobe is high during a write to offset 4 or offset 5. The set strobe is high during a read of offset 3 or offset 4. Neither strobe is high for any other access.
- R10: A write to offset 5 acts as a master clear. It zeroes the command, the status (software flags and terminal counts) and the mode counter, and it sets all mask bits. Channel modes keep their values.
- R11: A read of offset 5 (the temporary register) returns 0x00.
- R12: With ADDR_SHIFT = 1, the offset is taken from address bits [3:1] and address bit 0 has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | ADDR_SHIFT+3 | Control offset (word-spaced when ADDR_SHIFT=1) |
| wr_en | input | 1 | Write access strobe, one cycle |
| rd_en | input | 1 | Read access strobe, one cycle |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data, valid while rd_en is high |
| bptr_clr | output | 1 | Clear strobe for the shared byte pointer |
| bptr_set | output | 1 | Set strobe for the shared byte pointer |
| hw_req | input | 4 | Per-channel hardware request level |
| tc_set | input | 4 | Per-channel terminal-count pulse |
| svc_req | output | 4 | Per-channel service request |

## Verification
The bench sweeps all 256 command values. A design that checked the wrong set of unsupported bits would store a rejected value, or drop an accepted one.

It writes all 256 mode values and reads each back through the counter, including the wrap from channel 3 to channel 0. A design with a bad counter step or a missing forced-ones field would return the wrong byte.

Service request is swept over every combination of mask, request and enable. It also covers the race between a terminal-count pulse and a status read; a design that let the clear win would lose that event.

Master clear is checked against state that was deliberately made non-idle. A design that also wiped the modes, or left the counter where it was, would show it on the next mode read.

// File: rtl/dmactl_pkg.sv
// Shared constants and encodings for the DMA control-register port.
// Assumes exactly four channels, since a 2-bit field names the channel.
package dmactl_pkg;
    localparam int CH_N  = 4;
    localparam int CH_W  = $clog2(CH_N);
    localparam int OFF_N = 8;

    // Meaning of each control offset on a write.
    typedef enum logic [2:0] {
        W_CMD     = 3'd0,
        W_SWREQ   = 3'd1,
        W_MASK1   = 3'd2,
        W_MODE    = 3'd3,
        W_BPCLR   = 3'd4,
        W_MCLR    = 3'd5,
        W_UNMASK  = 3'd6,
        W_MASKALL = 3'd7
    } wr_off_e;

    // Meaning of each control offset on a read.
    typedef enum logic [2:0] {
        R_STAT    = 3'd0,
        R_REQ     = 3'd1,
        R_CMD     = 3'd2,
        R_MODE    = 3'd3,
        R_BPSET   = 3'd4,
        R_TEMP    = 3'd5,
        R_CTRCLR  = 3'd6,
        R_MASK    = 3'd7
    } rd_off_e;

    // Operating mode held in mode bits [7:6].
    typedef enum logic [1:0] {
        OP_DEMAND  = 2'd0,
        OP_SINGLE  = 2'd1,
        OP_BLOCK   = 2'd2,
        OP_CASCADE = 2'd3
    } opmode_e;

    localparam logic [7:0] CMD_UNSUP   = 8'hEB;
    localparam int         CMD_OFF_BIT = 2;
    localparam logic [7:0] TEMP_VAL    = 8'h00;
endpackage

// File: rtl/dmactl_decode.sv
// Offset decoder: turns a bus address and the access strobes into one-hot
// write and read hits. ADDR_SHIFT picks byte spacing (0) or word spacing
// (1), where the low address bit is ignored. Assumes wr_en and rd_en are
// never high together.
module dmactl_decode
    import dmactl_pkg::*;
#(
    parameter int ADDR_SHIFT = 0
) (
    input  logic [ADDR_SHIFT+2:0] addr,
    input  logic                  wr_en,
    input  logic                  rd_en,
    output logic [OFF_N-1:0]      wr_hit,
    output logic [OFF_N-1:0]      rd_hit,
    output logic [2:0]            off
);
    generate
        if (ADDR_SHIFT == 0) begin : g_byte
            assign off = addr[2:0];
        end else begin : g_word
            logic unused_lo;
            assign unused_lo = ^addr[ADDR_SHIFT-1:0];
            assign off = addr[ADDR_SHIFT +: 3];
        end
    endgenerate

    // One-hot hit vectors for the selected offset.
    always_comb begin
        wr_hit      = '0;
        rd_hit      = '0;
        wr_hit[off] = wr_en;
        rd_hit[off] = rd_en;
    end
endmodule

// File: rtl/dmactl_chan.sv
// Per-channel state: mode byte, mask bit, software request flag and
// terminal-count flag. Assumes at most one register strobe per cycle.
// Master clear touches every flag but leaves the mode byte alone.
module dmactl_chan
    import dmactl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mclr,
    input  logic       pick,
    input  logic       wr_swreq,
    input  logic       wr_mask1,
    input  logic       wr_mode,
    input  logic       wr_unmask,
    input  logic       wr_maskall,
    input  logic       maskall_bit,
    input  logic [7:0] data,
    input  logic       stat_rd,
    input  logic       tc_in,
    input  logic       hw_req,
    output logic [7:0] mode_q,
    output logic       mask_q,
    output logic       req_o,
    output logic       tc_q
);
    logic sw_q;

    // Mode byte: loaded by a mode write aimed at this channel.
    always_ff @(posedge clk) begin
        if (!rst_n)                mode_q <= 8'h00;
        else if (wr_mode && pick)  mode_q <= data;
    end

    // Mask bit: set by reset or master clear, otherwise written by software.
    always_ff @(posedge clk) begin
        if (!rst_n || mclr)         mask_q <= 1'b1;
        else if (wr_maskall)        mask_q <= maskall_bit;
        else if (wr_unmask)         mask_q <= 1'b0;
        else if (wr_mask1 && pick)  mask_q <= data[2];
    end

    // Software request flag.
    always_ff @(posedge clk) begin
        if (!rst_n || mclr)         sw_q <= 1'b0;
        else if (wr_swreq && pick)  sw_q <= data[2];
    end

    // Terminal-count flag: a new event wins over either clearing source.
    always_ff @(posedge clk) begin
        if (!rst_n || mclr)
            tc_q <= 1'b0;
        else if (tc_in && (opmode_e'(mode_q[7:6]) != OP_CASCADE))
            tc_q <= 1'b1;
        else if (stat_rd || (wr_swreq && pick))
            tc_q <= 1'b0;
    end

    // Effective request seen by status and service logic.
    assign req_o = sw_q | hw_req;

    // R7: a cascade channel never gains a terminal count.
    a_r7_cascade_no_tc: assert property (@(posedge clk) disable iff (!rst_n)
        (tc_in && mode_q[7:6] == 2'b11 && !tc_q) |=> !tc_q);

    // R3: a software-request write to this channel leaves its terminal count clear.
    a_r3_swreq_clears_tc: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_swreq && pick && !tc_in) |=> !tc_q);
endmodule

// File: rtl/dma_ctl_port.sv
// Control-register port of a four-channel DMA controller: command, status,
// mask, channel modes and the mode readback counter, plus the strobes for
// a shared byte pointer and per-channel service requests. Read data is
// combinational while rd_en is high; read side effects land on the edge
// that ends the access. Assumes wr_en and rd_en are never high together.
module dma_ctl_port
    import dmactl_pkg::*;
#(
    parameter int ADDR_SHIFT = 0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_SHIFT+2:0] addr,
    input  logic                  wr_en,
    input  logic                  rd_en,
    input  logic [7:0]            wr_data,
    output logic [7:0]            rd_data,
    output logic                  bptr_clr,
    output logic                  bptr_set,
    input  logic [CH_N-1:0]       hw_req,
    input  logic [CH_N-1:0]       tc_set,
    output logic [CH_N-1:0]       svc_req
);
    logic [OFF_N-1:0] wr_hit, rd_hit;
    logic [2:0]       off;
    logic [7:0]       cmd_q;
    logic [CH_W-1:0]  mctr;
    logic             mclr;
    logic [CH_N-1:0]  mask_v, req_v, tc_v;
    logic [7:0]       mode_v [CH_N];

    dmactl_decode #(.ADDR_SHIFT(ADDR_SHIFT)) u_dec (
        .addr   (addr),
        .wr_en  (wr_en),
        .rd_en  (rd_en),
        .wr_hit (wr_hit),
        .rd_hit (rd_hit),
        .off    (off)
    );

    assign mclr = wr_hit[W_MCLR];

    genvar i;
    generate
        for (i = 0; i < CH_N; i++) begin : g_ch
            dmactl_chan u_ch (
                .clk         (clk),
                .rst_n       (rst_n),
                .mclr        (mclr),
                .pick        (wr_data[CH_W-1:0] == CH_W'(i)),
                .wr_swreq    (wr_hit[W_SWREQ]),
                .wr_mask1    (wr_hit[W_MASK1]),
                .wr_mode     (wr_hit[W_MODE]),
                .wr_unmask   (wr_hit[W_UNMASK]),
                .wr_maskall  (wr_hit[W_MASKALL]),
                .maskall_bit (wr_data[i]),
                .data        (wr_data),
                .stat_rd     (rd_hit[R_STAT]),
                .tc_in       (tc_set[i]),
                .hw_req      (hw_req[i]),
                .mode_q      (mode_v[i]),
                .mask_q      (mask_v[i]),
                .req_o       (req_v[i]),
                .tc_q        (tc_v[i])
            );
            // Service request for one channel.
            assign svc_req[i] = !cmd_q[CMD_OFF_BIT] && !mask_v[i] && req_v[i];
        end
    endgenerate

    // Command register: rejects any value carrying an unsupported bit.
    always_ff @(posedge clk) begin
        if (!rst_n || mclr)
            cmd_q <= 8'h00;
        else if (wr_hit[W_CMD] && ((wr_data & CMD_UNSUP) == 8'h00))
            cmd_q <= wr_data;
    end

    // Mode readback counter: cleared by its own read, stepped by mode reads.
    always_ff @(posedge clk) begin
        if (!rst_n || mclr)        mctr <= '0;
        else if (rd_hit[R_CTRCLR]) mctr <= '0;
        else if (rd_hit[R_MODE])   mctr <= mctr + 1'b1;
    end

    // Byte-pointer strobes, valid during the access itself.
    assign bptr_clr = wr_hit[W_BPCLR] | mclr;
    assign bptr_set = rd_hit[R_BPSET] | rd_hit[R_MODE];

    // Read data multiplexer.
    always_comb begin
        rd_data = 8'h00;
        if (rd_en) begin
            case (rd_off_e'(off))
                R_STAT:  rd_data = {req_v, tc_v};
                R_REQ:   rd_data = {4'hF, req_v};
                R_CMD:   rd_data = cmd_q;
                R_MODE:  rd_data = mode_v[mctr] | 8'h03;
                R_TEMP:  rd_data = TEMP_VAL;
                R_MASK:  rd_data = {4'h0, mask_v};
                default: rd_data = 8'h00;
            endcase
        end
    end

    // R2: a rejected command write leaves the command untouched.
    a_r2_cmd_reject: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit[W_CMD] && ((wr_data & CMD_UNSUP) != 8'h00)) |=> $stable(cmd_q));

    // R6: a status read with no new event leaves all terminal counts clear.
    a_r6_stat_clears_tc: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hit[R_STAT] && tc_set == '0) |=> tc_v == '0);

    // R5: each mode read steps the counter by one, modulo four.
    a_r5_ctr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hit[R_MODE] && !mclr) |=> mctr == CH_W'($past(mctr) + 1'b1));

    // R10: master clear leaves every channel masked and the command and counter zero.
    a_r10_mclr_state: assert property (@(posedge clk) disable iff (!rst_n)
        mclr |=> (mask_v == '1 && cmd_q == 8'h00 && mctr == '0));

    // R8: writing the disable command silences all service requests.
    a_r8_disable_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit[W_CMD] && wr_data == 8'h04) |=> svc_req == '0);
endmodule

// File: tb/dma_ctl_port_tb_top.sv
module dma_ctl_port_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] addr = '0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       bptr_clr, bptr_set;
    logic [3:0] hw_req = '0, tc_set = '0, svc_req;

    logic [3:0] w_addr = '0;
    logic       w_wr = 1'b0, w_rd = 1'b0;
    logic [7:0] w_wdata = '0, w_rdata;
    logic       w_bc, w_bs;
    logic [3:0] w_svc;
    logic [3:0] zero4 = '0;

    int nchk = 0, nbad = 0;

    logic [7:0] m_cmd;
    logic [3:0] m_sw;
    logic [7:0] m_mode [4];

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_ctl_port #(.ADDR_SHIFT(0)) dut_i (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wr_data(wr_data), .rd_data(rd_data), .bptr_clr(bptr_clr),
        .bptr_set(bptr_set), .hw_req(hw_req), .tc_set(tc_set), .svc_req(svc_req));

    dma_ctl_port #(.ADDR_SHIFT(1)) dut_w (
        .clk(clk), .rst_n(rst_n), .addr(w_addr), .wr_en(w_wr), .rd_en(w_rd),
        .wr_data(w_wdata), .rd_data(w_rdata), .bptr_clr(w_bc),
        .bptr_set(w_bs), .hw_req(zero4), .tc_set(zero4), .svc_req(w_svc));

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        nchk++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    endtask

    // One access cycle on the byte-spaced instance.
    task automatic acc(input bit w, input logic [2:0] off, input logic [7:0] d,
                       output logic [7:0] rv, output logic bc, output logic bs);
        @(negedge clk);
        addr = off; wr_en = w; rd_en = !w; wr_data = d;
        #1;
        rv = rd_data; bc = bptr_clr; bs = bptr_set;
        @(posedge clk); #1;
        wr_en = 1'b0; rd_en = 1'b0;
    endtask

    task automatic wr(input logic [2:0] off, input logic [7:0] d);
        logic [7:0] rv; logic bc, bs;
        acc(1'b1, off, d, rv, bc, bs);
    endtask

    task automatic rd_chk(input logic [2:0] off, input logic [7:0] exp, input string tag);
        logic [7:0] rv; logic bc, bs;
        acc(1'b0, off, 8'h00, rv, bc, bs);
        chk(tag, rv, exp);
    endtask

    task automatic tc_pulse(input logic [3:0] v);
        @(negedge clk); tc_set = v;
        @(posedge clk); #1; tc_set = '0;
    endtask

    // One access cycle on the word-spaced instance.
    task automatic wacc(input bit w, input logic [3:0] a, input logic [7:0] d, output logic [7:0] rv);
        @(negedge clk);
        w_addr = a; w_wr = w; w_rd = !w; w_wdata = d;
        #1; rv = w_rdata;
        @(posedge clk); #1;
        w_wr = 1'b0; w_rd = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nbad++;
        $display("FAIL watchdog: actual=running expected=done");
        summary();
    end

    initial begin
        logic [7:0] rv; logic bc, bs;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1: reset state
        rd_chk(3'd0, 8'h00, "R1 status");
        rd_chk(3'd1, 8'hF0, "R1 request");
        rd_chk(3'd2, 8'h00, "R1 command");
        rd_chk(3'd7, 8'h0F, "R1 mask");
        rd_chk(3'd3, 8'h03, "R1 mode");
        chk("R1 svc", {4'h0, svc_req}, 8'h00);
        m_cmd = 8'h00; m_sw = 4'h0;
        for (int c = 0; c < 4; c++) m_mode[c] = 8'h00;

        // R2: every command value, accepted or rejected
        for (int v = 0; v < 256; v++) begin
            wr(3'd0, 8'(v));
            if ((8'(v) & 8'hEB) == 8'h00) m_cmd = 8'(v);
            rd_chk(3'd2, m_cmd, "R2 command readback");
        end
        wr(3'd0, 8'h00); m_cmd = 8'h00;

        // R4: mask writes of all three kinds
        begin
            logic [3:0] mm;
            wr(3'd6, 8'h00); mm = 4'h0;
            rd_chk(3'd7, 8'h00, "R4 unmask all");
            for (int d = 0; d < 8; d++) begin
                wr(3'd2, 8'(d) | 8'h30);
                mm[d & 3] = d[2];
                rd_chk(3'd7, {4'h0, mm}, "R4 single mask");
            end
            for (int d = 0; d < 16; d++) begin
                wr(3'd7, 8'(d) | 8'hA0);
                rd_chk(3'd7, 8'(d), "R4 write all masks");
            end
        end

        // R8: service request over mask x request x enable
        for (int en = 0; en < 2; en++) begin
            wr(3'd0, en ? 8'h00 : 8'h04);
            for (int m = 0; m < 16; m++) begin
                wr(3'd7, 8'(m));
                for (int h = 0; h < 16; h++) begin
                    @(negedge clk); hw_req = 4'(h); #1;
                    chk("R8 svc_req", {4'h0, svc_req},
                        en ? {4'h0, ~4'(m) & 4'(h)} : 8'h00);
                end
            end
        end
        @(negedge clk); hw_req = 4'h0;
        wr(3'd0, 8'h00); wr(3'd6, 8'h00);

        // R3: software request sweep, and its clearing of terminal count
        for (int d = 0; d < 8; d++) begin
            wr(3'd1, 8'(d));
            m_sw[d & 3] = d[2];
            rd_chk(3'd1, {4'hF, m_sw}, "R3 request readback");
            #1 chk("R3 svc follows flag", {4'h0, svc_req}, {4'h0, m_sw});
        end
        tc_pulse(4'hF);
        wr(3'd1, 8'h05); m_sw[1] = 1'b1;
        rd_chk(3'd0, {m_sw, 4'b1101}, "R3 clears own terminal count");

        // R6: status read clears terminal counts; request is sw OR hw
        rd_chk(3'd0, {m_sw, 4'h0}, "R6 second status read");
        @(negedge clk); hw_req = 4'b0100;
        rd_chk(3'd1, {4'hF, m_sw | 4'b0100}, "R6 request OR");
        rd_chk(3'd0, {m_sw | 4'b0100, 4'h0}, "R6 status request nibble");
        @(negedge clk); hw_req = 4'h0;

        // R7: cascade channel ignores terminal count; set wins over clear
        wr(3'd3, 8'hC0); wr(3'd3, 8'h41); wr(3'd3, 8'h82); wr(3'd3, 8'h03);
        tc_pulse(4'hF);
        rd_chk(3'd0, {m_sw, 4'b1110}, "R7 cascade ignored");
        @(negedge clk);
        addr = 3'd0; rd_en = 1'b1; tc_set = 4'b0010;
        #1 chk("R7 status during race", rd_data, {m_sw, 4'h0});
        @(posedge clk); #1; rd_en = 1'b0; tc_set = 4'h0;
        rd_chk(3'd0, {m_sw, 4'b0010}, "R7 set wins");

        // R5: every mode value through the readback counter
        for (int v = 0; v < 256; v++) begin
            wr(3'd3, 8'(v));
            m_mode[v & 3] = 8'(v);
            rd_chk(3'd6, 8'h00, "R5 counter clear read");
            for (int k = 0; k < (v & 3); k++)
                rd_chk(3'd3, m_mode[k] | 8'h03, "R5 walk");
            rd_chk(3'd3, 8'(v) | 8'h03, "R5 mode readback");
        end
        wr(3'd3, 8'h84); wr(3'd3, 8'h49); wr(3'd3, 8'h1A); wr(3'd3, 8'h67);
        rd_chk(3'd6, 8'h00, "R5 counter clear");
        rd_chk(3'd3, 8'h87, "R5 ch0");
        rd_chk(3'd3, 8'h4B, "R5 ch1");
        rd_chk(3'd3, 8'h1B, "R5 ch2");
        rd_chk(3'd3, 8'h67, "R5 ch3");
        rd_chk(3'd3, 8'h87, "R5 wrap to ch0");

        // R9: byte-pointer strobes
        acc(1'b1, 3'd4, 8'h00, rv, bc, bs);
        chk("R9 clr on offset 4 write", {6'h0, bc, bs}, 8'h02);
        acc(1'b0, 3'd4, 8'h00, rv, bc, bs);
        chk("R9 set on offset 4 read", {6'h0, bc, bs}, 8'h01);
        acc(1'b0, 3'd3, 8'h00, rv, bc, bs);
        chk("R9 set on mode read", {6'h0, bc, bs}, 8'h01);
        acc(1'b1, 3'd0, 8'h00, rv, bc, bs);
        chk("R9 quiet on command write", {6'h0, bc, bs}, 8'h00);
        acc(1'b0, 3'd0, 8'h00, rv, bc, bs);
        chk("R9 quiet on status read", {6'h0, bc, bs}, 8'h00);

        // R11: temporary register
        rd_chk(3'd5, 8'h00, "R11 temp");

        // R10: master clear from a busy state
        wr(3'd0, 8'h10); wr(3'd6, 8'h00); wr(3'd1, 8'h06);
        tc_pulse(4'b1000);
        rd_chk(3'd6, 8'h00, "R10 setup counter clear");
        rd_chk(3'd3, 8'h87, "R10 setup mode read");
        acc(1'b1, 3'd5, 8'h00, rv, bc, bs);
        chk("R10 clr strobe", {7'h0, bc}, 8'h01);
        rd_chk(3'd2, 8'h00, "R10 command");
        rd_chk(3'd0, 8'h00, "R10 status");
        rd_chk(3'd7, 8'h0F, "R10 mask");
        rd_chk(3'd3, 8'h87, "R10 counter zero, modes kept");
        chk("R10 svc", {4'h0, svc_req}, 8'h00);

        // R12: word-spaced decoder ignores address bit 0
        wacc(1'b1, 4'h1, 8'h10, rv);
        wacc(1'b0, 4'h4, 8'h00, rv); chk("R12 command via odd addr", rv, 8'h10);
        wacc(1'b0, 4'h5, 8'h00, rv); chk("R12 alias read", rv, 8'h10);
        wacc(1'b1, 4'hF, 8'h05, rv);
        wacc(1'b0, 4'hE, 8'h00, rv); chk("R12 mask via word offset", rv, 8'h05);
        wacc(1'b0, 4'h2, 8'h00, rv); chk("R12 request read", rv, 8'hF0);

        summary();
    end
endmodule